// File: doc/BRIEF.md
# Inter-Core Mailbox Doorbell Unit

This block gives each core of a multi-core cluster a small set of 32-bit doorbell words. Any core may post bits into any core's mailbox by writing to that mailbox's set alias; only ones in the written word take effect, so several posters never need a read-modify-write. The receiving core reads the mailbox through its clear alias and acknowledges the bits it has handled by writing ones back to that same alias.

Each core has a small enable register. It turns a non-empty mailbox into either a normal interrupt request or a fast interrupt request for that core. A read-only pending word per core reports which mailboxes are currently requesting service. Register access uses one read port with registered data, one cycle after the request, and a parameterised number of write ports that act in the same cycle. This lets two agents post to and acknowledge the same mailbox at once.

Top module: `doorbell_hub`

## Requirements
- R1: After a synchronous reset every mailbox word, every enable register and the read data are zero, and no irq_o or fiq_o line is asserted.
- R2: A write to byte offset 0x80 + 16·n + 4·m ORs the written value into mailbox m of core n; bits written as zero keep their value and other mailboxes are untouched.
- R3: A write to byte offset 0xC0 + 16·n + 4·m clears exactly the bits of mailbox m of core n that are one in the written value.
- R4: A read of offset 0xC0 + 16·n + 4·m returns the mailbox contents on rd_data one cycle after rd_en, and repeated reads leave the contents unchanged.
- R5: The enable register of core n sits at offset 0x50 + 4·n; bit m enables the normal request and bit m+4 the fast request for mailbox m, and bits 8 to 31 read as zero.
- R6: irq_o[n] is high one cycle after some mailbox m of core n holds a non-zero word while its normal enable is on and its fast enable is off; fiq_o[n] is high one cycle after some mailbox with a non-zero word has its fast enable on.
- R7: When both enables of a mailbox are on, only the fast request is raised for it; irq_o[n] and fiq_o[n] are never both driven by that one mailbox.
- R8: The read-only word at offset 0x60 + 4·n has bit 4+m set while mailbox m of core n is non-zero and has either enable on; all other bits read zero, and writes to it are ignored.
- R9: Writes from different ports in one cycle to one mailbox combine: all set values are ORed in, and clears are applied before sets, so a bit both cleared and posted ends up set.
- R10: Reads of unmapped or misaligned offsets, and of the set aliases, return zero; writes to unmapped or misaligned offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NUM_WPORTS | Write strobe, one per write port |
| wr_addr | input | NUM_WPORTS·ADDR_W | Byte offset per write port, port p in slice p |
| wr_data | input | NUM_WPORTS·DATA_W | Write value per write port, port p in slice p |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Read value, registered, valid the cycle after rd_en |
| irq_o | output | NUM_CORES | Normal mailbox interrupt request per core |
| fiq_o | output | NUM_CORES | Fast mailbox interrupt request per core |

## Verification
The hardest case to reach is a set and a clear of the same mailbox in one clock cycle. A single register port can never produce it. The bench drives two write ports in the same cycle: one port clears every bit of a mailbox that already holds a value while the other posts a new value, and a second pass posts two different values at once. Reading the mailbox back shows whether the clear was ordered before the set and whether simultaneous posts merge.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

  // Kind of register an offset selects.
  typedef enum logic [2:0] {
    ACC_NONE = 3'd0,
    ACC_CFG  = 3'd1,
    ACC_PEND = 3'd2,
    ACC_SET  = 3'd3,
    ACC_CLR  = 3'd4
  } acc_kind_e;

endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
  import doorbell_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NC        = 4,
  parameter int unsigned NB        = 4,
  parameter int unsigned CFG_BASE  = 32'h50,
  parameter int unsigned PEND_BASE = 32'h60,
  parameter int unsigned SET_BASE  = 32'h80,
  parameter int unsigned CLR_BASE  = 32'hC0,
  parameter int unsigned CORE_W    = 2,
  parameter int unsigned SLOT_W    = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [CORE_W-1:0] core_o,
  output logic [SLOT_W-1:0] slot_o
);

  localparam int unsigned WORD_B  = 4;
  localparam int unsigned CORE_SZ = NC * WORD_B;
  localparam int unsigned BOX_SZ  = NC * NB * WORD_B;

  int unsigned a_int;
  int unsigned idx;

  always_comb begin
    kind_o = ACC_NONE;
    core_o = '0;
    slot_o = '0;
    idx    = 0;
    a_int  = 32'(addr_i);
    if (addr_i[1:0] == 2'b00) begin
      if (a_int >= CFG_BASE && a_int < CFG_BASE + CORE_SZ) begin
        kind_o = ACC_CFG;
        idx    = (a_int - CFG_BASE) / WORD_B;
        core_o = CORE_W'(idx);
      end else if (a_int >= PEND_BASE && a_int < PEND_BASE + CORE_SZ) begin
        kind_o = ACC_PEND;
        idx    = (a_int - PEND_BASE) / WORD_B;
        core_o = CORE_W'(idx);
      end else if (a_int >= SET_BASE && a_int < SET_BASE + BOX_SZ) begin
        kind_o = ACC_SET;
        idx    = (a_int - SET_BASE) / WORD_B;
        core_o = CORE_W'(idx / NB);
        slot_o = SLOT_W'(idx);
      end else if (a_int >= CLR_BASE && a_int < CLR_BASE + BOX_SZ) begin
        kind_o = ACC_CLR;
        idx    = (a_int - CLR_BASE) / WORD_B;
        core_o = CORE_W'(idx / NB);
        slot_o = SLOT_W'(idx);
      end
    end
  end

endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_bits,
  input  logic [DW-1:0] clr_bits,
  output logic [DW-1:0] word_q,
  output logic          nonempty
);

  // Clear first, then post: a bit posted in the same cycle survives.
  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= (word_q & ~clr_bits) | set_bits;
  end

  assign nonempty = |word_q;

endmodule

// File: rtl/doorbell_core_gate.sv
module doorbell_core_gate #(
  parameter int unsigned NB = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [2*NB-1:0] cfg_wd,
  input  logic [NB-1:0]   nonempty,
  output logic [2*NB-1:0] cfg_q,
  output logic [NB-1:0]   pend_o,
  output logic            irq_o,
  output logic            fiq_o
);

  logic [NB-1:0] irq_en;
  logic [NB-1:0] fiq_en;
  logic [NB-1:0] irq_src;
  logic [NB-1:0] fiq_src;

  assign irq_en = cfg_q[NB-1:0];
  assign fiq_en = cfg_q[2*NB-1:NB];

  // Fast request wins when a mailbox has both enables on.
  assign fiq_src = nonempty & fiq_en;
  assign irq_src = nonempty & irq_en & ~fiq_en;
  assign pend_o  = nonempty & (irq_en | fiq_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wd;
      irq_o <= |irq_src;
      fiq_o <= |fiq_src;
    end
  end

endmodule

// File: rtl/doorbell_hub.sv
module doorbell_hub
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned BOXES      = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NUM_WPORTS = 2,
  parameter int unsigned CFG_BASE   = 32'h50,
  parameter int unsigned PEND_BASE  = 32'h60,
  parameter int unsigned SET_BASE   = 32'h80,
  parameter int unsigned CLR_BASE   = 32'hC0,
  parameter int unsigned PEND_LSB   = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_WPORTS-1:0]        wr_en,
  input  logic [NUM_WPORTS*ADDR_W-1:0] wr_addr,
  input  logic [NUM_WPORTS*DATA_W-1:0] wr_data,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic [NUM_CORES-1:0]         irq_o,
  output logic [NUM_CORES-1:0]         fiq_o
);

  localparam int unsigned SLOTS  = NUM_CORES * BOXES;
  localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned CFG_W  = 2 * BOXES;

  // Per write port decode results.
  acc_kind_e         wr_kind [NUM_WPORTS];
  logic [CORE_W-1:0] wr_core [NUM_WPORTS];
  logic [SLOT_W-1:0] wr_slot [NUM_WPORTS];

  // Read decode results.
  acc_kind_e         rd_kind;
  logic [CORE_W-1:0] rd_core;
  logic [SLOT_W-1:0] rd_slot;

  // Mailbox state and per-cycle update masks.
  logic [SLOTS-1:0][DATA_W-1:0]    box_q;
  logic [SLOTS-1:0][DATA_W-1:0]    set_mask;
  logic [SLOTS-1:0][DATA_W-1:0]    clr_mask;
  logic [SLOTS-1:0]                box_ne;

  // Per-core enable registers and their write controls.
  logic [NUM_CORES-1:0]             cfg_we;
  logic [NUM_CORES-1:0][CFG_W-1:0]  cfg_wd;
  logic [NUM_CORES-1:0][CFG_W-1:0]  cfg_q;
  logic [NUM_CORES-1:0][BOXES-1:0]  pend;

  genvar gp, gs, gc;

  generate
    for (gp = 0; gp < NUM_WPORTS; gp++) begin : g_wdec
      doorbell_decode #(
        .ADDR_W(ADDR_W), .NC(NUM_CORES), .NB(BOXES),
        .CFG_BASE(CFG_BASE), .PEND_BASE(PEND_BASE),
        .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE),
        .CORE_W(CORE_W), .SLOT_W(SLOT_W)
      ) u_dec (
        .addr_i (wr_addr[gp*ADDR_W +: ADDR_W]),
        .kind_o (wr_kind[gp]),
        .core_o (wr_core[gp]),
        .slot_o (wr_slot[gp])
      );
    end
  endgenerate

  doorbell_decode #(
    .ADDR_W(ADDR_W), .NC(NUM_CORES), .NB(BOXES),
    .CFG_BASE(CFG_BASE), .PEND_BASE(PEND_BASE),
    .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE),
    .CORE_W(CORE_W), .SLOT_W(SLOT_W)
  ) u_rd_dec (
    .addr_i (rd_addr),
    .kind_o (rd_kind),
    .core_o (rd_core),
    .slot_o (rd_slot)
  );

  // Merge all write ports; for enable writes the highest port wins.
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    cfg_we   = '0;
    cfg_wd   = '0;
    for (int p = 0; p < NUM_WPORTS; p++) begin
      if (wr_en[p]) begin
        unique case (wr_kind[p])
          ACC_SET: set_mask[wr_slot[p]] = set_mask[wr_slot[p]] | wr_data[p*DATA_W +: DATA_W];
          ACC_CLR: clr_mask[wr_slot[p]] = clr_mask[wr_slot[p]] | wr_data[p*DATA_W +: DATA_W];
          ACC_CFG: begin
            cfg_we[wr_core[p]] = 1'b1;
            cfg_wd[wr_core[p]] = wr_data[p*DATA_W +: CFG_W];
          end
          default: ;
        endcase
      end
    end
  end

  generate
    for (gs = 0; gs < SLOTS; gs++) begin : g_box
      doorbell_mailbox #(.DW(DATA_W)) u_box (
        .clk      (clk),
        .rst      (rst),
        .set_bits (set_mask[gs]),
        .clr_bits (clr_mask[gs]),
        .word_q   (box_q[gs]),
        .nonempty (box_ne[gs])
      );
    end

    for (gc = 0; gc < NUM_CORES; gc++) begin : g_core
      doorbell_core_gate #(.NB(BOXES)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we[gc]),
        .cfg_wd   (cfg_wd[gc]),
        .nonempty (box_ne[gc*BOXES +: BOXES]),
        .cfg_q    (cfg_q[gc]),
        .pend_o   (pend[gc]),
        .irq_o    (irq_o[gc]),
        .fiq_o    (fiq_o[gc])
      );
    end
  endgenerate

  // Registered read mux; set aliases and holes read as zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      unique case (rd_kind)
        ACC_CFG:  rd_data <= DATA_W'(cfg_q[rd_core]);
        ACC_PEND: rd_data <= DATA_W'(pend[rd_core]) << PEND_LSB;
        ACC_CLR:  rd_data <= box_q[rd_slot];
        default:  rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/doorbell_hub_chk.sv
module doorbell_hub_chk
  import doorbell_pkg::*;
#(
  parameter int unsigned NC     = 4,
  parameter int unsigned NB     = 4,
  parameter int unsigned DW     = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NC-1:0]               irq_o,
  input logic [NC-1:0]               fiq_o,
  input logic                        rd_en,
  input acc_kind_e                   rd_kind,
  input logic [DW-1:0]               rd_data,
  input logic [NC*NB-1:0][DW-1:0]    box_q,
  input logic [NC*NB-1:0][DW-1:0]    set_mask,
  input logic [NC*NB-1:0][DW-1:0]    clr_mask,
  input logic [NC-1:0][2*NB-1:0]     cfg_q
);

  logic [NC-1:0][NB-1:0] ne;

  always_comb begin
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++)
        ne[c][b] = |box_q[c*NB+b];
  end

  // R1: the cycle after reset all requests are low.
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (irq_o == '0 && fiq_o == '0));

  // R10: a read of an unmapped offset returns zero.
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && $past(rd_kind) == ACC_NONE) |-> rd_data == '0);

  genvar gc, gs;
  generate
    for (gc = 0; gc < NC; gc++) begin : g_c
      // R7: never both requests on one core from a single mailbox with both enables.
      assert_fiq_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_o[gc] && fiq_o[gc]) |->
          $past((ne[gc] & cfg_q[gc][NB-1:0] & ~cfg_q[gc][2*NB-1:NB]) != '0));
      // R6: a normal request needs an enabled, non-empty mailbox in the prior cycle.
      assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
        irq_o[gc] |-> $past((ne[gc] & cfg_q[gc][NB-1:0]) != '0));
      // R6: a fast request needs a fast-enabled, non-empty mailbox in the prior cycle.
      assert_fiq_cause_R6: assert property (@(posedge clk) disable iff (rst)
        fiq_o[gc] |-> $past((ne[gc] & cfg_q[gc][2*NB-1:NB]) != '0));
    end
    for (gs = 0; gs < NC*NB; gs++) begin : g_s
      // R3: bits only drop where a clear was written.
      assert_drop_needs_clear_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(box_q[gs]) & ~box_q[gs] & ~$past(clr_mask[gs])) == '0));
      // R9: posted bits are present next cycle even with a clear in the same cycle.
      assert_set_survives_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(set_mask[gs]) & ~box_q[gs]) == '0));
    end
  endgenerate

endmodule

bind doorbell_hub doorbell_hub_chk #(
  .NC(NUM_CORES), .NB(BOXES), .DW(DATA_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .rd_en    (rd_en),
  .rd_kind  (rd_kind),
  .rd_data  (rd_data),
  .box_q    (box_q),
  .set_mask (set_mask),
  .clr_mask (clr_mask),
  .cfg_q    (cfg_q)
);

// File: tb/doorbell_hub_tb_top.sv
`timescale 1ns/1ps
module doorbell_hub_tb_top;

  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    wr_en = '0;
  logic [2*AW-1:0] wr_addr = '0;
  logic [2*DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [3:0]    irq_o;
  logic [3:0]    fiq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  doorbell_hub dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 2'b01; wr_addr[7:0] = a; wr_data[31:0] = d;
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic wr2(input logic [7:0] a0, input logic [31:0] d0,
                     input logic [7:0] a1, input logic [31:0] d1);
    @(negedge clk);
    wr_en = 2'b11; wr_addr = {a1, a0}; wr_data = {d1, d0};
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 fiq", 32'(fiq_o), 0);
    chk("R1 rd_data", rd_data, 0);
    rd(8'h58, v); chk("R1 cfg core2", v, 0);
    rd(8'hFC, v); chk("R1 box core3/3", v, 0);
  endtask

  task automatic t_set_or();
    logic [31:0] v;
    wr(8'h98, 32'h0000_00F0);
    wr(8'h98, 32'h0F00_000F);
    rd(8'hD8, v); chk("R2 or-merge", v, 32'h0F00_00FF);
    rd(8'hD4, v); chk("R2 neighbour untouched", v, 0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(8'hD8, 32'h0000_00F1);
    rd(8'hD8, v); chk("R3 clear ones", v, 32'h0F00_000E);
    rd(8'hD8, v); chk("R4 reread unchanged", v, 32'h0F00_000E);
    wr(8'hD8, 32'hFFFF_FFFF);
    rd(8'hD8, v); chk("R3 clear all", v, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    wr(8'h58, 32'hFFFF_FF12);
    rd(8'h58, v); chk("R5 cfg low byte only", v, 32'h12);
    wr(8'h58, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(8'h50, 32'h01);
    wr(8'h80, 32'h1);
    @(negedge clk);
    chk("R6 irq core0", 32'(irq_o), 32'h1);
    chk("R6 no fiq", 32'(fiq_o), 0);
    wr(8'h84, 32'h1);
    rd(8'h60, v); chk("R8 pending only enabled box", v, 32'h10);
    wr(8'hC0, 32'h1);
    @(negedge clk);
    chk("R6 irq drops after ack", 32'(irq_o), 0);
    wr(8'hC4, 32'hFFFF_FFFF);
    wr(8'h50, 32'h0);
  endtask

  task automatic t_fiq();
    logic [31:0] v;
    wr(8'h5C, 32'h88);
    wr(8'hBC, 32'h8000_0000);
    @(negedge clk);
    chk("R7 fiq core3", 32'(fiq_o), 32'h8);
    chk("R7 irq suppressed", 32'(irq_o), 0);
    rd(8'h6C, v); chk("R8 pending box3", v, 32'h80);
    wr(8'h5C, 32'h08);
    @(negedge clk);
    chk("R6 irq core3", 32'(irq_o), 32'h8);
    chk("R6 fiq off", 32'(fiq_o), 0);
    wr(8'hFC, 32'hFFFF_FFFF);
    wr(8'h5C, 32'h0);
  endtask

  task automatic t_concurrent();
    logic [31:0] v;
    wr(8'hA4, 32'h0000_00A0);
    wr2(8'hE4, 32'hFFFF_FFFF, 8'hA4, 32'h0000_0005);
    rd(8'hE4, v); chk("R9 clear then set", v, 32'h5);
    wr2(8'hA4, 32'h100, 8'hA4, 32'h200);
    rd(8'hE4, v); chk("R9 two posts merge", v, 32'h305);
    wr2(8'hE4, 32'h300, 8'hA4, 32'h100);
    rd(8'hE4, v); chk("R9 same bit clear and set", v, 32'h105);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h81, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h51, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R10 hole reads zero", v, 0);
    rd(8'h81, v); chk("R10 misaligned read zero", v, 0);
    rd(8'h70, v); chk("R10 past pending zero", v, 0);
    rd(8'hC0, v); chk("R10 misaligned write ignored", v, 0);
    rd(8'h50, v); chk("R10 misaligned cfg write ignored", v, 0);
    rd(8'h60, v); chk("R8 pending write ignored", v, 0);
    rd(8'hA4, v); chk("R10 set alias reads zero", v, 0);
    @(negedge clk);
    chk("R10 no requests", 32'({irq_o, fiq_o}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set_or();
    t_clear();
    t_cfg();
    t_irq();
    t_fiq();
    t_concurrent();
    t_unmapped();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule